// File: doc/BRIEF.md
# Register File with Fixed-Role Entries

This block is the architectural register store of a five-stage pipelined integer core. It holds `NUM_REGS` words of `DATA_W` bits. It offers two combinational read ports for the decode stage and one synchronous writeback port. Most entries are plain storage, but four of them have a fixed role. Entry 0 is a hard zero. One entry receives characters from a keyboard front end. One entry is a stack pointer that moves by itself when the pipeline pushes or pops. One entry captures the return address of a call.

Each role is fed by a sideband strobe: `push_stb`, `pop_stb`, `link_stb` and `key_valid`. The normal writeback port always has priority over every sideband update aimed at the same entry. A value being written back is also visible on a read port in the same cycle. Because of this, the decode stage needs no separate bypass from writeback. The positions of the special entries, the reset top-of-stack address and the stack step are parameters. Elaboration checks that these settings are consistent.

Top module: `spreg_file`

## Requirements
- R1: Synchronous active-high `rst` clears every entry to zero, except the stack-pointer entry (default index 30), which is set to `SP_TOP` (default 32'h0003_FFFF).
- R2: Reading entry 0 on either port returns zero. A writeback to entry 0 is discarded, including during the cycle of the write.
- R3: When `wr_en` is high, `wr_data` is stored into entry `wr_addr` at the rising edge. All other entries keep their value.
- R4: `push_stb` alone lowers the stack pointer by `SP_STEP` (default 1) at the edge. `pop_stb` alone raises it by `SP_STEP`. If both are high, the pointer is unchanged.
- R5: `key_valid` loads `key_char` (8 bits), zero-extended, into the input entry (default index 29). A writeback to that entry in the same cycle wins.
- R6: If `wr_en` is high and `wr_addr` equals a nonzero read address, that read port returns `wr_data` in the same cycle. Sideband updates become visible only after the edge.
- R7: `link_stb` loads `link_addr` into the link entry (default index 31). A writeback to that entry in the same cycle wins.
- R8: A writeback to the stack-pointer entry overrides a push or pop in the same cycle.
- R9: Every special entry except entry 0 can be written through the normal writeback port and read on either read port, like a general entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A index |
| rd_data_a | output | 32 | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B index |
| rd_data_b | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Writeback enable |
| wr_addr | input | 5 | Writeback index |
| wr_data | input | 32 | Writeback data |
| push_stb | input | 1 | Push: pre-decrement stack pointer |
| pop_stb | input | 1 | Pop: post-increment stack pointer |
| link_stb | input | 1 | Call: capture link address |
| link_addr | input | 32 | Return address to capture |
| key_valid | input | 1 | Keyboard character available |
| key_char | input | 8 | ASCII code from the keyboard front end |

## Verification
The bench targets the collisions in which a sideband strobe and a writeback hit the same entry. A design that gave the strobe priority would show the keyboard byte, the link address or the stepped stack pointer where the written value belongs. Pushing and popping together must leave the pointer unchanged, so a design that let one strobe dominate would drift by one word. Same-cycle reads of the entry being written must return the new data on both ports, which a stale read would not. The bench also writes entry 0 while reading it, to catch any bypass that leaks the written data past the hard zero. A byte of 8'hFF is loaded to expose sign extension instead of zero extension.

// File: rtl/spreg_pkg.sv
package spreg_pkg;

   typedef enum logic [2:0] {
      ROLE_ZERO,
      ROLE_GP,
      ROLE_IO,
      ROLE_SP,
      ROLE_LINK
   } role_e;

   function automatic role_e role_of(input int idx, input int io_idx,
                                     input int sp_idx, input int link_idx);
      if (idx == 0)             return ROLE_ZERO;
      else if (idx == io_idx)   return ROLE_IO;
      else if (idx == sp_idx)   return ROLE_SP;
      else if (idx == link_idx) return ROLE_LINK;
      else                      return ROLE_GP;
   endfunction

endpackage

// File: rtl/spreg_cell.sv
module spreg_cell
   import spreg_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter role_e       ROLE      = ROLE_GP,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wb_hit,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              side_en,
   input  logic [DATA_W-1:0] side_data,
   output logic [DATA_W-1:0] q
);

   generate
      if (ROLE == ROLE_ZERO) begin : g_hard_zero
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst, wb_hit, wb_data, side_en, side_data};
         assign q = '0;
      end else begin : g_store
         logic [DATA_W-1:0] q_r;
         always_ff @(posedge clk) begin
            if (rst)          q_r <= RESET_VAL;
            else if (wb_hit)  q_r <= wb_data;
            else if (side_en) q_r <= side_data;
         end
         assign q = q_r;
      end
   endgenerate

endmodule

// File: rtl/spreg_sp_unit.sv
module spreg_sp_unit #(
   parameter int DATA_W  = 32,
   parameter int SP_STEP = 1
) (
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] sp_q,
   output logic              sp_upd,
   output logic [DATA_W-1:0] sp_next
);

   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(SP_STEP);

   always_comb begin
      sp_upd  = push ^ pop;
      sp_next = push ? (sp_q - STEP_V) : (sp_q + STEP_V);
   end

endmodule

// File: rtl/spreg_read_port.sv
module spreg_read_port #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 32,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [ADDR_W-1:0]               rd_addr,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   output logic [DATA_W-1:0]               rd_data
);

   logic fwd;

   always_comb begin
      fwd = wr_en && (wr_addr == rd_addr) && (rd_addr != '0);
      rd_data = fwd ? wr_data : regs[rd_addr];
   end

endmodule

// File: rtl/spreg_file.sv
module spreg_file
   import spreg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 32,
   parameter int KEY_W    = 8,
   parameter int IO_IDX   = 29,
   parameter int SP_IDX   = 30,
   parameter int LINK_IDX = 31,
   parameter int SP_STEP  = 1,
   parameter logic [DATA_W-1:0] SP_TOP = 32'h0003_FFFF,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              push_stb,
   input  logic              pop_stb,
   input  logic              link_stb,
   input  logic [DATA_W-1:0] link_addr,
   input  logic              key_valid,
   input  logic [KEY_W-1:0]  key_char
);

   // elaboration-time parameter checks
   generate
      if (NUM_REGS < 4 || (1 << ADDR_W) != NUM_REGS) begin : g_bad_depth
         $error("spreg_file: NUM_REGS must be a power of two >= 4");
      end
      if (IO_IDX <= 0 || SP_IDX <= 0 || LINK_IDX <= 0 ||
          IO_IDX >= NUM_REGS || SP_IDX >= NUM_REGS || LINK_IDX >= NUM_REGS) begin : g_bad_idx
         $error("spreg_file: special indices must be in 1..NUM_REGS-1");
      end
      if (IO_IDX == SP_IDX || IO_IDX == LINK_IDX || SP_IDX == LINK_IDX) begin : g_dup_idx
         $error("spreg_file: special indices must be distinct");
      end
      if (KEY_W > DATA_W || KEY_W < 1) begin : g_bad_key
         $error("spreg_file: KEY_W must be within 1..DATA_W");
      end
      if (SP_STEP < 1) begin : g_bad_step
         $error("spreg_file: SP_STEP must be positive");
      end
   endgenerate

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic                            sp_upd;
   logic [DATA_W-1:0]               sp_next;
   logic [DATA_W-1:0]               key_ext;

   assign key_ext = {{(DATA_W-KEY_W){1'b0}}, key_char};

   spreg_sp_unit #(
      .DATA_W  (DATA_W),
      .SP_STEP (SP_STEP)
   ) u_sp (
      .push    (push_stb),
      .pop     (pop_stb),
      .sp_q    (regs_q[SP_IDX]),
      .sp_upd  (sp_upd),
      .sp_next (sp_next)
   );

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
         localparam role_e ROLE = role_of(i, IO_IDX, SP_IDX, LINK_IDX);
         localparam logic [DATA_W-1:0] RST_V = (ROLE == ROLE_SP) ? SP_TOP : '0;
         logic              hit;
         logic              s_en;
         logic [DATA_W-1:0] s_data;

         assign hit = wr_en && (wr_addr == ADDR_W'(i));

         if (ROLE == ROLE_IO) begin : g_io
            assign s_en   = key_valid;
            assign s_data = key_ext;
         end else if (ROLE == ROLE_SP) begin : g_sp
            assign s_en   = sp_upd;
            assign s_data = sp_next;
         end else if (ROLE == ROLE_LINK) begin : g_link
            assign s_en   = link_stb;
            assign s_data = link_addr;
         end else begin : g_plain
            assign s_en   = 1'b0;
            assign s_data = '0;
         end

         spreg_cell #(
            .DATA_W    (DATA_W),
            .ROLE      (ROLE),
            .RESET_VAL (RST_V)
         ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .wb_hit    (hit),
            .wb_data   (wr_data),
            .side_en   (s_en),
            .side_data (s_data),
            .q         (regs_q[i])
         );
      end
   endgenerate

   spreg_read_port #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_rd_a (
      .regs    (regs_q),
      .rd_addr (rd_addr_a),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_data (rd_data_a)
   );

   spreg_read_port #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_rd_b (
      .regs    (regs_q),
      .rd_addr (rd_addr_b),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_data (rd_data_b)
   );

endmodule

// File: rtl/spreg_file_chk.sv
module spreg_file_chk #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 32,
   parameter int KEY_W    = 8,
   parameter int IO_IDX   = 29,
   parameter int SP_IDX   = 30,
   parameter int LINK_IDX = 31,
   parameter int SP_STEP  = 1,
   parameter logic [DATA_W-1:0] SP_TOP = 32'h0003_FFFF,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input logic                            clk,
   input logic                            rst,
   input logic [ADDR_W-1:0]               rd_addr_a,
   input logic [DATA_W-1:0]               rd_data_a,
   input logic [ADDR_W-1:0]               rd_addr_b,
   input logic [DATA_W-1:0]               rd_data_b,
   input logic                            wr_en,
   input logic [ADDR_W-1:0]               wr_addr,
   input logic [DATA_W-1:0]               wr_data,
   input logic                            push_stb,
   input logic                            pop_stb,
   input logic                            link_stb,
   input logic [DATA_W-1:0]               link_addr,
   input logic                            key_valid,
   input logic [KEY_W-1:0]                key_char,
   input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(SP_STEP);

   logic wb_sp, wb_io, wb_link;
   assign wb_sp   = wr_en && (wr_addr == ADDR_W'(SP_IDX));
   assign wb_io   = wr_en && (wr_addr == ADDR_W'(IO_IDX));
   assign wb_link = wr_en && (wr_addr == ADDR_W'(LINK_IDX));

   p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (regs_q[SP_IDX] == SP_TOP) && (regs_q[1] == '0));

   p_zero_a_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == '0) |-> (rd_data_a == '0));

   p_zero_b_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_b == '0) |-> (rd_data_b == '0));

   p_write_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != '0) |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

   p_push_r4: assert property (@(posedge clk) disable iff (rst)
      (push_stb && !pop_stb && !wb_sp) |=> (regs_q[SP_IDX] == $past(regs_q[SP_IDX]) - STEP_V));

   p_pop_r4: assert property (@(posedge clk) disable iff (rst)
      (pop_stb && !push_stb && !wb_sp) |=> (regs_q[SP_IDX] == $past(regs_q[SP_IDX]) + STEP_V));

   p_sp_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (push_stb == pop_stb && !wb_sp) |=> $stable(regs_q[SP_IDX]));

   p_key_load_r5: assert property (@(posedge clk) disable iff (rst)
      (key_valid && !wb_io) |=> (regs_q[IO_IDX] == {{(DATA_W-KEY_W){1'b0}}, $past(key_char)}));

   p_bypass_a_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == rd_addr_a && rd_addr_a != '0) |-> (rd_data_a == wr_data));

   p_bypass_b_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == rd_addr_b && rd_addr_b != '0) |-> (rd_data_b == wr_data));

   p_link_r7: assert property (@(posedge clk) disable iff (rst)
      (link_stb && !wb_link) |=> (regs_q[LINK_IDX] == $past(link_addr)));

   p_sp_wb_wins_r8: assert property (@(posedge clk) disable iff (rst)
      wb_sp |=> (regs_q[SP_IDX] == $past(wr_data)));

endmodule

bind spreg_file spreg_file_chk #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .KEY_W    (KEY_W),
   .IO_IDX   (IO_IDX),
   .SP_IDX   (SP_IDX),
   .LINK_IDX (LINK_IDX),
   .SP_STEP  (SP_STEP),
   .SP_TOP   (SP_TOP)
) u_chk (.*);

// File: tb/spreg_file_tb.sv
module spreg_file_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
   logic [31:0] rd_data_a, rd_data_b, wr_data, link_addr;
   logic        wr_en, push_stb, pop_stb, link_stb, key_valid;
   logic [7:0]  key_char;

   localparam logic [31:0] TOP = 32'h0003_FFFF;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   spreg_file dut_i (
      .clk (clk), .rst (rst),
      .rd_addr_a (rd_addr_a), .rd_data_a (rd_data_a),
      .rd_addr_b (rd_addr_b), .rd_data_b (rd_data_b),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .push_stb (push_stb), .pop_stb (pop_stb),
      .link_stb (link_stb), .link_addr (link_addr),
      .key_valid (key_valid), .key_char (key_char)
   );

   typedef struct packed {
      logic        we;
      logic [4:0]  wa;
      logic [31:0] wd;
      logic        push;
      logic        pop;
      logic        lnk;
      logic [31:0] la;
      logic        kv;
      logic [7:0]  kc;
      logic [4:0]  chk;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 5'd5,  32'hA5A5_0001, 1'b0, 1'b0, 1'b0, 32'h0,     1'b0, 8'h00, 5'd5,  32'hA5A5_0001, 4'd3}, // R3
      '{1'b1, 5'd0,  32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h0,     1'b0, 8'h00, 5'd0,  32'h0,         4'd2}, // R2
      '{1'b0, 5'd0,  32'h0,         1'b1, 1'b0, 1'b0, 32'h0,     1'b0, 8'h00, 5'd30, 32'h0003_FFFE, 4'd4}, // R4 push
      '{1'b0, 5'd0,  32'h0,         1'b1, 1'b0, 1'b0, 32'h0,     1'b0, 8'h00, 5'd30, 32'h0003_FFFD, 4'd4}, // R4 push
      '{1'b0, 5'd0,  32'h0,         1'b0, 1'b1, 1'b0, 32'h0,     1'b0, 8'h00, 5'd30, 32'h0003_FFFE, 4'd4}, // R4 pop
      '{1'b0, 5'd0,  32'h0,         1'b1, 1'b1, 1'b0, 32'h0,     1'b0, 8'h00, 5'd30, 32'h0003_FFFE, 4'd4}, // R4 both
      '{1'b0, 5'd0,  32'h0,         1'b0, 1'b0, 1'b0, 32'h0,     1'b1, 8'h41, 5'd29, 32'h0000_0041, 4'd5}, // R5
      '{1'b1, 5'd29, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 32'h0,     1'b1, 8'h7A, 5'd29, 32'h1234_5678, 4'd5}, // R5 wb wins
      '{1'b0, 5'd0,  32'h0,         1'b0, 1'b0, 1'b1, 32'h400,   1'b0, 8'h00, 5'd31, 32'h0000_0400, 4'd7}, // R7
      '{1'b1, 5'd31, 32'h0000_BEEF, 1'b0, 1'b0, 1'b1, 32'h800,   1'b0, 8'h00, 5'd31, 32'h0000_BEEF, 4'd7}, // R7 wb wins
      '{1'b1, 5'd30, 32'h0000_1000, 1'b0, 1'b1, 1'b0, 32'h0,     1'b0, 8'h00, 5'd30, 32'h0000_1000, 4'd8}, // R8 pop
      '{1'b1, 5'd30, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0,     1'b0, 8'h00, 5'd30, 32'h0000_2000, 4'd8}, // R8 push
      '{1'b1, 5'd31, 32'h0000_CAFE, 1'b0, 1'b0, 1'b0, 32'h0,     1'b0, 8'h00, 5'd31, 32'h0000_CAFE, 4'd9}, // R9
      '{1'b1, 5'd1,  32'h0000_0011, 1'b0, 1'b0, 1'b0, 32'h0,     1'b0, 8'h00, 5'd5,  32'hA5A5_0001, 4'd3}, // R3 others kept
      '{1'b0, 5'd0,  32'h0,         1'b0, 1'b0, 1'b0, 32'h0,     1'b1, 8'hFF, 5'd29, 32'h0000_00FF, 4'd5}  // R5 zero-ext
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      push_stb = 1'b0; pop_stb = 1'b0; link_stb = 1'b0; link_addr = '0;
      key_valid = 1'b0; key_char = '0;
   endtask

   task automatic run_vec(input vec_t v);
      @(negedge clk);
      wr_en = v.we; wr_addr = v.wa; wr_data = v.wd;
      push_stb = v.push; pop_stb = v.pop; link_stb = v.lnk; link_addr = v.la;
      key_valid = v.kv; key_char = v.kc;
      rd_addr_a = v.chk; rd_addr_b = v.chk;
      @(negedge clk);
      idle_inputs();
      #2;
      check($sformatf("R%0d vec port A", v.req), rd_data_a, v.exp);
      check($sformatf("R%0d vec port B", v.req), rd_data_b, v.exp);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rd_addr_a = '0; rd_addr_b = '0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      rd_addr_a = 5'd30; rd_addr_b = 5'd1;
      #2;
      check("R1 stack pointer after reset", rd_data_a, TOP);
      check("R1 general entry after reset", rd_data_b, 32'h0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R6: same-cycle read of the entry being written, both ports
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h0707_7777;
      rd_addr_a = 5'd7; rd_addr_b = 5'd7;
      #2;
      check("R6 bypass port A", rd_data_a, 32'h0707_7777);
      check("R6 bypass port B", rd_data_b, 32'h0707_7777);
      @(negedge clk);
      idle_inputs();
      #2;
      check("R6 value held after edge", rd_data_a, 32'h0707_7777);

      // R2: writing entry 0 while reading it must not leak through
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hDEAD_BEEF;
      rd_addr_a = 5'd0; rd_addr_b = 5'd0;
      #2;
      check("R2 zero during write port A", rd_data_a, 32'h0);
      check("R2 zero during write port B", rd_data_b, 32'h0);

      // R6: sideband update not visible before the edge
      @(negedge clk);
      idle_inputs();
      key_valid = 1'b1; key_char = 8'h33; rd_addr_a = 5'd29;
      #2;
      check("R6 sideband not bypassed", rd_data_a, 32'h0000_00FF);
      @(negedge clk);
      idle_inputs();

      // R1: reset mid-run restores state
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      rd_addr_a = 5'd5; rd_addr_b = 5'd30;
      #2;
      check("R1 general entry cleared", rd_data_a, 32'h0);
      check("R1 stack pointer restored", rd_data_b, TOP);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule